// File: doc/BRIEF.md
# Strap-Selected Boot Configuration Loader

This block brings a device out of reset into a known register state. On the first clock after reset it samples a mode strap, two page-select pins and an address strap. When the mode strap reads high, the device runs stand-alone. The two select pins then pick one of four stored configuration pages. When the mode strap reads low, the device is managed by a host over a serial bus. The select pins then serve as that bus's clock and data, and page 0 is always loaded. The loader copies the chosen page into an active register bank, one word per clock, and then raises `boot_done`.

After boot, a host in serial mode may rewrite the active bank. Two control bits in bank word 10 can restart the boot: bit 1 (power-down) and bit 4 (idle). A restart happens when either bit goes from 1 back to 0, and the straps are sampled afresh. While either bit is held at 1, the block stays quiet. The host can also ask for the active bank to be burned into page 0 of the stored configuration. This can be done only once.

Top module: `boot_cfg_ctrl`

## Requirements
- R1: The mode strap is sampled on the first clock after reset release or after a restart. High selects stand-alone mode (`mode_serial`=0). Low selects serial mode (`mode_serial`=1).
- R2: In stand-alone mode, `page_idx` = {`sel1_sda`,`sel0_scl`}. After boot, bank word i holds the factory value (37·p + 11·i + 5) mod 256 of page p. Word 10 is the exception: its bits 1 and 4 are always loaded as 0.
- R3: In serial mode, `page_idx` is 0 whatever the select pins read. Page 0 is loaded, and `bus_addr` equals the sampled address strap.
- R4: Strap changes after sampling leave `mode_serial`, `page_idx` and `bus_addr` unchanged until the next restart.
- R5: During reset, `boot_done` is 0 and the bank reads 0. The bank is copied one word per clock, and `boot_done` reads 1 after exactly NUM_WORDS+1 rising edges following reset release.
- R6: A host write takes effect only in serial mode, after `boot_done`, and while no programming is running. Writes during the copy or in stand-alone mode leave the bank unchanged.
- R7: Setting word 10 bit 1 raises `standby` and does not restart the block. Clearing the bit restarts the boot: `boot_done` drops one edge after the clearing write, and the straps are sampled afresh.
- R8: Word 10 bit 4 behaves the same way as bit 1 described in R7.
- R9: An accepted `prog_req` makes `prog_busy` high for NUM_WORDS cycles while the bank is written into page 0. It then sets `programmed`, which stays set. Later boots load page 0 from the burned values.
- R10: A `prog_req` seen while `programmed` is set is refused. Page 0 keeps its contents, and `prog_err` is high for exactly one cycle after the request.
- R11: A restart through a register bit keeps both `programmed` and the burned contents of page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| mode_strap | input | 1 | Mode strap, high for stand-alone mode |
| sel0_scl | input | 1 | Page select bit 0, or serial clock in serial mode |
| sel1_sda | input | 1 | Page select bit 1, or serial data in serial mode |
| addr_strap | input | ADDR_PIN_W | Decoded address strap |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | IDX_W | Host write word index |
| host_wr_data | input | WORD_W | Host write data |
| host_rd_addr | input | IDX_W | Host read word index |
| host_rd_data | output | WORD_W | Active bank word at `host_rd_addr` |
| prog_req | input | 1 | Request to burn the bank into page 0 |
| boot_done | output | 1 | Bank copy finished |
| mode_serial | output | 1 | Held mode, 1 for serial mode |
| page_idx | output | 2 | Held source page index |
| bus_addr | output | ADDR_PIN_W | Held serial bus address |
| standby | output | 1 | A restart control bit is held at 1 |
| prog_busy | output | 1 | Burn in progress |
| programmed | output | 1 | Sticky burned flag |
| prog_err | output | 1 | One-cycle refusal pulse |

## Verification
The bench sweeps all four stand-alone pages and all four address straps, and compares every bank word. A loader with the wrong page decode or a missing control-bit mask would show a wrong word. A wrong copy length would shift the cycle in which `boot_done` rises. The bench moves the straps after boot to catch a design that samples them continuously. It also holds each control bit at 1 for several cycles, so a design that restarts on the level would drop `boot_done` early. Finally, it asks for a second burn and then restarts. A design without the lock would overwrite page 0 or lose `programmed`.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;

    typedef enum logic [1:0] {
        SQ_SAMPLE = 2'd0,
        SQ_COPY   = 2'd1,
        SQ_DONE   = 2'd2
    } seq_state_e;

    // Factory content of stored page `page`, word `idx`, before truncation
    function automatic logic [31:0] factory_word(input int unsigned page,
                                                 input int unsigned idx);
        return 32'(page * 37 + idx * 11 + 5);
    endfunction

endpackage

// File: rtl/boot_strap_latch.sv
module boot_strap_latch #(
    parameter int ADDR_PIN_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic                  mode_strap,
    input  logic [1:0]            sel_pins,
    input  logic [ADDR_PIN_W-1:0] addr_strap,
    output logic                  serial_mode,
    output logic [1:0]            page_idx,
    output logic [ADDR_PIN_W-1:0] bus_addr
);

    typedef struct packed {
        logic                  serial;
        logic [1:0]            page;
        logic [ADDR_PIN_W-1:0] addr;
    } strap_t;

    strap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.serial = ~mode_strap;
            // select pins are bus lines in serial mode: page 0 only
            st_d.page   = mode_strap ? sel_pins : 2'd0;
            st_d.addr   = addr_strap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign serial_mode = st_q.serial;
    assign page_idx    = st_q.page;
    assign bus_addr    = st_q.addr;

    assert_straps_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(st_q));

endmodule

// File: rtl/boot_copy_seq.sv
module boot_copy_seq
    import boot_cfg_pkg::*;
#(
    parameter int NUM_WORDS = 16,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic             capture,
    output logic             copy_en,
    output logic [IDX_W-1:0] copy_idx,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        unique case (sq_q.state)
            SQ_SAMPLE: begin
                sq_d.state = SQ_COPY;
                sq_d.idx   = '0;
            end
            SQ_COPY: begin
                sq_d.idx = sq_q.idx + 1'b1;
                if (sq_q.idx == LAST) sq_d.state = SQ_DONE;
            end
            SQ_DONE: begin
                if (restart) sq_d.state = SQ_SAMPLE;
            end
            default: sq_d.state = SQ_SAMPLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{state: SQ_SAMPLE, idx: '0};
        else        sq_q <= sq_d;
    end

    assign capture  = (sq_q.state == SQ_SAMPLE);
    assign copy_en  = (sq_q.state == SQ_COPY);
    assign done     = (sq_q.state == SQ_DONE);
    assign copy_idx = sq_q.idx;

    assert_restart_samples_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && restart) |=> capture);
    assert_copy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(copy_en) && $past(copy_idx) == LAST));

endmodule

// File: rtl/boot_nv_store.sv
module boot_nv_store
    import boot_cfg_pkg::*;
#(
    parameter int NUM_WORDS = 16,
    parameter int WORD_W    = 8,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rd_page,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic              prog_start,
    input  logic [WORD_W-1:0] prog_data,
    output logic [IDX_W-1:0]  prog_idx,
    output logic              prog_busy,
    output logic              programmed
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

    typedef struct packed {
        logic                              busy;
        logic [IDX_W-1:0]                  idx;
        logic                              burned;
        logic [NUM_WORDS-1:0][WORD_W-1:0]  page0;
    } nv_t;

    nv_t nv_d, nv_q;

    // factory pages, computed rather than tabulated
    logic [3:0][NUM_WORDS-1:0][WORD_W-1:0] factory;
    for (genvar gp = 0; gp < 4; gp++) begin : g_page
        for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
            assign factory[gp][gi] = WORD_W'(factory_word(gp, gi));
        end
    end

    always_comb begin
        nv_d = nv_q;
        if (nv_q.busy) begin
            nv_d.page0[nv_q.idx] = prog_data;
            nv_d.idx             = nv_q.idx + 1'b1;
            if (nv_q.idx == LAST) begin
                nv_d.busy   = 1'b0;
                nv_d.burned = 1'b1;
            end
        end else if (prog_start && !nv_q.burned) begin
            nv_d.busy = 1'b1;
            nv_d.idx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nv_q <= '0;
        else        nv_q <= nv_d;
    end

    assign rd_data    = (nv_q.burned && rd_page == 2'd0) ? nv_q.page0[rd_idx]
                                                          : factory[rd_page][rd_idx];
    assign prog_idx   = nv_q.idx;
    assign prog_busy  = nv_q.busy;
    assign programmed = nv_q.burned;

    assert_burn_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        programmed |=> programmed);
    assert_single_burn_R10: assert property (@(posedge clk) disable iff (!rst_n)
        programmed |=> $stable(nv_q.page0));
    assert_busy_before_burn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> !programmed);

endmodule

// File: rtl/boot_cfg_ctrl.sv
module boot_cfg_ctrl
    import boot_cfg_pkg::*;
#(
    parameter int NUM_WORDS  = 16,
    parameter int WORD_W     = 8,
    parameter int ADDR_PIN_W = 2,
    parameter int CTRL_IDX   = 10,
    parameter int PDN_BIT    = 1,
    parameter int IDLE_BIT   = 4,
    localparam int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_strap,
    input  logic                  sel0_scl,
    input  logic                  sel1_sda,
    input  logic [ADDR_PIN_W-1:0] addr_strap,
    input  logic                  host_wr_en,
    input  logic [IDX_W-1:0]      host_addr,
    input  logic [WORD_W-1:0]     host_wr_data,
    input  logic [IDX_W-1:0]      host_rd_addr,
    output logic [WORD_W-1:0]     host_rd_data,
    input  logic                  prog_req,
    output logic                  boot_done,
    output logic                  mode_serial,
    output logic [1:0]            page_idx,
    output logic [ADDR_PIN_W-1:0] bus_addr,
    output logic                  standby,
    output logic                  prog_busy,
    output logic                  programmed,
    output logic                  prog_err
);

    localparam logic [WORD_W-1:0] CTRL_MASK =
        ~((WORD_W'(1) << PDN_BIT) | (WORD_W'(1) << IDLE_BIT));

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] bank;
        logic [1:0]                       ctrl_prev;
        logic                             err;
    } top_t;

    top_t tp_d, tp_q;

    logic             capture, copy_en, restart, prog_ok, wr_ok;
    logic [IDX_W-1:0] copy_idx, prog_idx;
    logic [WORD_W-1:0] page_word;
    logic [1:0]       ctrl_now;

    boot_strap_latch #(.ADDR_PIN_W(ADDR_PIN_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .mode_strap (mode_strap),
        .sel_pins   ({sel1_sda, sel0_scl}),
        .addr_strap (addr_strap),
        .serial_mode(mode_serial),
        .page_idx   (page_idx),
        .bus_addr   (bus_addr)
    );

    boot_copy_seq #(.NUM_WORDS(NUM_WORDS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .capture (capture),
        .copy_en (copy_en),
        .copy_idx(copy_idx),
        .done    (boot_done)
    );

    boot_nv_store #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_page   (page_idx),
        .rd_idx    (copy_idx),
        .rd_data   (page_word),
        .prog_start(prog_ok),
        .prog_data (tp_q.bank[prog_idx]),
        .prog_idx  (prog_idx),
        .prog_busy (prog_busy),
        .programmed(programmed)
    );

    assign ctrl_now = {tp_q.bank[CTRL_IDX][IDLE_BIT], tp_q.bank[CTRL_IDX][PDN_BIT]};
    // restart on a 1 -> 0 transition of either control bit, never on a level
    assign restart  = boot_done && |(tp_q.ctrl_prev & ~ctrl_now);
    assign wr_ok    = host_wr_en && boot_done && mode_serial && !prog_busy;
    assign prog_ok  = prog_req && boot_done && mode_serial && !prog_busy && !programmed;

    always_comb begin
        tp_d           = tp_q;
        tp_d.ctrl_prev = ctrl_now;
        tp_d.err       = prog_req && programmed;
        if (copy_en) begin
            tp_d.bank[copy_idx] = (copy_idx == IDX_W'(CTRL_IDX)) ? (page_word & CTRL_MASK)
                                                                 : page_word;
        end else if (wr_ok) begin
            tp_d.bank[host_addr] = host_wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    assign host_rd_data = tp_q.bank[host_rd_addr];
    assign standby      = |ctrl_now;
    assign prog_err     = tp_q.err;

    assert_page0_serial_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done && mode_serial) |-> page_idx == 2'd0);
    assert_err_after_burn_R10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |-> programmed);
    assert_no_early_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_done && !copy_en) |=> $stable(tp_q.bank));
    assert_stand_alone_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done && !mode_serial && !restart) |=> $stable(tp_q.bank));

endmodule

// File: tb/boot_cfg_ctrl_bench.sv
`timescale 1ns/1ps
module boot_cfg_ctrl_bench;

    localparam int NW = 16;
    localparam int WW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_strap = 1'b0, sel0_scl = 1'b0, sel1_sda = 1'b0;
    logic [1:0] addr_strap = '0;
    logic       host_wr_en = 1'b0;
    logic [3:0] host_addr = '0, host_rd_addr = '0;
    logic [7:0] host_wr_data = '0;
    logic [7:0] host_rd_data;
    logic       prog_req = 1'b0;
    logic       boot_done, mode_serial, standby, prog_busy, programmed, prog_err;
    logic [1:0] page_idx, bus_addr;

    int n_chk = 0, n_bad = 0;
    logic [7:0] burned [NW];

    always #4 clk = ~clk;

    boot_cfg_ctrl u_boot_cfg_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .sel0_scl(sel0_scl),
        .sel1_sda(sel1_sda), .addr_strap(addr_strap), .host_wr_en(host_wr_en),
        .host_addr(host_addr), .host_wr_data(host_wr_data), .host_rd_addr(host_rd_addr),
        .host_rd_data(host_rd_data), .prog_req(prog_req), .boot_done(boot_done),
        .mode_serial(mode_serial), .page_idx(page_idx), .bus_addr(bus_addr),
        .standby(standby), .prog_busy(prog_busy), .programmed(programmed),
        .prog_err(prog_err)
    );

    function automatic logic [7:0] exp_word(int p, int i);
        logic [7:0] w = 8'((p * 37 + i * 11 + 5) % 256);
        if (i == 10) w = w & 8'hED;
        return w;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_done(string req);
        for (int k = 0; k < 100; k++) begin
            if (boot_done) break;
            @(negedge clk);
        end
        check(req, boot_done, 1);
    endtask

    task automatic boot(logic m, logic [1:0] sel, logic [1:0] a);
        int n = 0;
        mode_strap = m; {sel1_sda, sel0_scl} = sel; addr_strap = a;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 100; k++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (boot_done) break;
        end
        check("R5 latency", n, NW + 1);
    endtask

    task automatic wr(int adr, int dat);
        host_addr = 4'(adr); host_wr_data = 8'(dat); host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic rd_check(string req, int adr, int exp);
        host_rd_addr = 4'(adr);
        #1;
        check(req, host_rd_data, exp);
    endtask

    task automatic pulse_bit(int val);
        wr(10, val);
        check("R7/R8 standby while held", standby, 1);
        repeat (6) @(negedge clk);
        check("R7/R8 no restart while held", boot_done, 1);
        wr(10, 0);
        @(negedge clk);
        check("R7/R8 restart on clear", boot_done, 0);
        wait_done("R7/R8 reboot");
    endtask

    initial begin
        // reset state
        repeat (2) @(negedge clk);
        check("R5 done in reset", boot_done, 0);
        rd_check("R5 bank in reset", 3, 0);

        // stand-alone: every page
        for (int p = 0; p < 4; p++) begin
            boot(1'b1, 2'(p), 2'(p ^ 3));
            check("R1 stand-alone mode", mode_serial, 0);
            check("R2 page index", page_idx, p);
            for (int i = 0; i < NW; i++) rd_check("R2 page word", i, exp_word(p, i));
        end

        // stand-alone: host write ignored
        boot(1'b1, 2'd1, 2'd0);
        wr(2, ~exp_word(1, 2));
        rd_check("R6 write ignored stand-alone", 2, exp_word(1, 2));

        // serial: every address
        for (int a = 0; a < 4; a++) begin
            boot(1'b0, 2'(3 - a), 2'(a));
            check("R1 serial mode", mode_serial, 1);
            check("R3 page forced 0", page_idx, 0);
            check("R3 bus address", bus_addr, a);
            for (int i = 0; i < NW; i++) rd_check("R3 page0 word", i, exp_word(0, i));
        end

        // straps moved after sampling
        mode_strap = 1'b1; {sel1_sda, sel0_scl} = 2'd3; addr_strap = 2'd1;
        repeat (5) @(negedge clk);
        check("R4 mode held", mode_serial, 1);
        check("R4 page held", page_idx, 0);
        check("R4 addr held", bus_addr, 3);

        // write during copy is ignored
        mode_strap = 1'b0; addr_strap = 2'd0;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        wr(0, 8'hEE);
        wait_done("R5 done");
        rd_check("R6 write during copy ignored", 0, exp_word(0, 0));

        // serial write accepted
        wr(3, 8'h5C);
        rd_check("R6 serial write", 3, 8'h5C);

        // idle bit restart with new address strap
        boot(1'b0, 2'd0, 2'd1);
        wr(3, 8'h77);
        addr_strap = 2'd3;
        pulse_bit(8'h10);
        check("R8 fresh address", bus_addr, 3);
        rd_check("R8 bank reloaded", 3, exp_word(0, 3));

        // power-down bit restart into stand-alone page 2
        mode_strap = 1'b1; {sel1_sda, sel0_scl} = 2'd2;
        wr(10, 8'h02);
        check("R7 standby while held", standby, 1);
        repeat (6) @(negedge clk);
        check("R7 no restart while held", boot_done, 1);
        check("R7 mode unchanged while held", mode_serial, 1);
        wr(10, 0);
        @(negedge clk);
        check("R7 restart on clear", boot_done, 0);
        wait_done("R7 reboot");
        check("R7 fresh mode", mode_serial, 0);
        check("R7 fresh page", page_idx, 2);
        for (int i = 0; i < NW; i++) rd_check("R7 page2 word", i, exp_word(2, i));

        // burn once
        boot(1'b0, 2'd0, 2'd0);
        for (int i = 0; i < NW; i++) begin
            burned[i] = 8'((i * 29 + 3) % 256);
            if (i == 10) burned[i] = burned[i] & 8'hED;
            wr(i, burned[i]);
        end
        check("R9 not burned yet", programmed, 0);
        prog_req = 1'b1;
        @(negedge clk);
        prog_req = 1'b0;
        begin
            int n = 0;
            while (prog_busy && n < 100) begin
                @(negedge clk); n++;
            end
            check("R9 burn cycles", n, NW);
        end
        check("R9 burned flag", programmed, 1);
        wr(5, 8'hAA);
        pulse_bit(8'h10);
        check("R11 flag kept", programmed, 1);
        for (int i = 0; i < NW; i++) rd_check("R9/R11 burned word", i, burned[i]);

        // second burn refused
        wr(7, 8'h00);
        prog_req = 1'b1;
        @(negedge clk);
        prog_req = 1'b0;
        check("R10 error pulse", prog_err, 1);
        check("R10 no busy", prog_busy, 0);
        @(negedge clk);
        check("R10 error one cycle", prog_err, 0);
        pulse_bit(8'h02);
        rd_check("R10 page0 kept", 7, burned[7]);
        check("R10 flag kept", programmed, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule